// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block is a small fully associative table that remembers which data loads were issued ahead of possibly conflicting stores. Each entry records the destination register tag, the access size and the byte address of one load. One request arrives per cycle. A request names an operation, says whether the target page permits speculation, carries a deferred-exception flag, and gives the register, address and size.

Advanced loads allocate or drop entries according to the page kind and the deferred flag. Check loads ask whether their load is still tracked and report a registered hit or miss. The clearing form consumes the entry. The keeping form may refresh the entry. Stores invalidate every entry whose byte range they overlap. A flush request empties the table.

When the table is full, entries are replaced in round-robin order. The table holds at most one entry per register tag. Load data, address translation, fault raising and the register file belong to other blocks.

Top module: `spec_load_table`

## Requirements
- R1: After reset, no entry is valid, `chk_done` and `chk_hit` are 0, and any check load misses.
- R2: Operation codes are 1 for a plain advanced load and 2 for a speculative advanced load. Size code s means 2^s bytes. On a speculative page (`req_spec_page`=1), code 1 always allocates an entry {register, address, size}. Code 2 allocates only when `req_defer`=0.
- R3: A speculative advanced load (code 2) with `req_defer`=1 removes any valid entry with the same register and allocates nothing.
- R4: An advanced load (code 1 or 2) to a non-speculative page removes any valid entry with the same register and never allocates.
- R5: A clearing check load (code 3) hits only when register, address and size all equal a valid entry. On a hit it removes that entry. On a miss the table is unchanged.
- R6: A keeping check load (code 4) to a speculative page behaves by match kind. On an exact match it reports a hit and leaves the table unchanged. On a miss it reports a miss and allocates its own entry. When only the register matches, it reports a miss and the entry is rewritten with the new address and size.
- R7: A check load (code 3 or 4) to a non-speculative page never allocates.
- R8: An allocation for a register that already has a valid entry overwrites that entry, so no two valid entries share a register.
- R9: An allocation with no same-register entry takes the lowest-numbered free slot. When all slots are valid, it takes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such a replacement.
- R10: A store (code 5) invalidates every valid entry whose byte range [addr, addr+2^size) overlaps the store's byte range. Entries that do not overlap are kept.
- R11: A flush request (code 6) clears every valid bit in one cycle.
- R12: `chk_done` and `chk_hit` are registered. They describe a check load one cycle after it is presented and are 0 after any other request. Table updates take effect at the same edge, so a request in the very next cycle sees them.
- R13: When `req_valid` is 0, the table and round-robin pointer are unchanged and `chk_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation code (0 none, 1..6 as in the requirements) |
| req_spec_page | input | 1 | Target page permits speculation |
| req_defer | input | 1 | Speculative load produced a deferred exception |
| req_reg | input | REG_W (7) | Destination register tag |
| req_addr | input | ADDR_W (16) | Byte address |
| req_size | input | SIZE_W (2) | Size code, 2^code bytes |
| chk_done | output | 1 | Previous cycle carried a check load |
| chk_hit | output | 1 | That check load matched exactly |

## Verification
A check load's `chk_done` and `chk_hit` are due on the first rising edge after the request. The bench drives each request at a falling edge and samples just after the next rising edge. Because the table updates at that same edge, every effect on the table is observed by a non-modifying probe request issued in the following cycle. The probe is a keeping check load to a non-speculative page, and its hit is read one cycle later in turn. Non-check requests are expected to leave `chk_done` at 0 in that same sampling slot.

// File: rtl/slt_pkg.sv
package slt_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE     = 3'd0,
        OP_ADV      = 3'd1,
        OP_SADV     = 3'd2,
        OP_CHK_CLR  = 3'd3,
        OP_CHK_KEEP = 3'd4,
        OP_STORE    = 3'd5,
        OP_FLUSH    = 3'd6
    } slt_op_e;
endpackage

// File: rtl/slt_match.sv
// Per-entry comparators: register match, exact match, byte-range overlap.
module slt_match #(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 16,
    parameter int SIZE_W  = 2
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][REG_W-1:0]  ent_reg,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
    input  logic [ENTRIES-1:0][SIZE_W-1:0] ent_size,
    input  logic [REG_W-1:0]               req_reg,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [SIZE_W-1:0]              req_size,
    output logic [ENTRIES-1:0]             reg_hit,
    output logic [ENTRIES-1:0]             exact_hit,
    output logic [ENTRIES-1:0]             overlap
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] req_lo, req_hi;
    assign req_lo = {1'b0, req_addr};
    assign req_hi = req_lo + (EXT_W'(1) << req_size);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [EXT_W-1:0] ent_lo, ent_hi;
        assign ent_lo       = {1'b0, ent_addr[i]};
        assign ent_hi       = ent_lo + (EXT_W'(1) << ent_size[i]);
        assign reg_hit[i]   = ent_valid[i] && (ent_reg[i] == req_reg);
        assign exact_hit[i] = reg_hit[i] && (ent_addr[i] == req_addr)
                              && (ent_size[i] == req_size);
        assign overlap[i]   = ent_valid[i] && (ent_lo < req_hi) && (req_lo < ent_hi);
    end
endmodule

// File: rtl/slt_victim.sv
// Slot choice for an allocation: same register, else lowest free, else pointer.
module slt_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] reg_hit,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_rr
);
    logic [IDX_W-1:0] free_idx, reg_idx;
    logic             any_free, any_reg;

    always_comb begin
        free_idx = '0;
        reg_idx  = '0;
        any_free = 1'b0;
        any_reg  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
            if (reg_hit[i]) begin
                reg_idx = IDX_W'(i);
                any_reg = 1'b1;
            end
        end
        use_rr = 1'b0;
        if (any_reg) begin
            slot = reg_idx;
        end else if (any_free) begin
            slot = free_idx;
        end else begin
            slot   = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 16,
    parameter int SIZE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_spec_page,
    input  logic              req_defer,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              chk_done,
    output logic              chk_hit
);
    import slt_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][REG_W-1:0]  rg;
        logic [ENTRIES-1:0][ADDR_W-1:0] ad;
        logic [ENTRIES-1:0][SIZE_W-1:0] sz;
        logic [IDX_W-1:0]               rr;
        logic                           done;
        logic                           hit;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0]            reg_hit, exact_hit, overlap;
    logic [IDX_W-1:0]              slot;
    logic                          use_rr;
    logic [ENTRIES-1:0]            ent_valid_q;
    logic [ENTRIES-1:0][REG_W-1:0] ent_reg_q;

    assign ent_valid_q = s_q.valid;
    assign ent_reg_q   = s_q.rg;

    slt_match #(
        .ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
    ) u_match (
        .ent_valid (s_q.valid),
        .ent_reg   (s_q.rg),
        .ent_addr  (s_q.ad),
        .ent_size  (s_q.sz),
        .req_reg   (req_reg),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .reg_hit   (reg_hit),
        .exact_hit (exact_hit),
        .overlap   (overlap)
    );

    slt_victim #(.ENTRIES(ENTRIES)) u_victim (
        .ent_valid (s_q.valid),
        .reg_hit   (reg_hit),
        .rr_ptr    (s_q.rr),
        .slot      (slot),
        .use_rr    (use_rr)
    );

    always_comb begin
        slt_op_e op;
        logic    alloc;
        op     = slt_op_e'(req_op);
        alloc  = 1'b0;
        s_d    = s_q;
        s_d.done = 1'b0;
        s_d.hit  = 1'b0;
        if (req_valid) begin  // R13: idle cycles leave everything alone
            case (op)
                OP_ADV, OP_SADV: begin
                    // R2 / R3 / R4
                    if (req_spec_page && !(op == OP_SADV && req_defer)) begin
                        alloc = 1'b1;
                    end else begin
                        s_d.valid = s_q.valid & ~reg_hit;
                    end
                end
                OP_CHK_CLR: begin
                    // R5
                    s_d.done  = 1'b1;
                    s_d.hit   = |exact_hit;
                    s_d.valid = s_q.valid & ~exact_hit;
                end
                OP_CHK_KEEP: begin
                    // R6 / R7
                    s_d.done = 1'b1;
                    s_d.hit  = |exact_hit;
                    alloc    = req_spec_page && !(|exact_hit);
                end
                OP_STORE: s_d.valid = s_q.valid & ~overlap;   // R10
                OP_FLUSH: s_d.valid = '0;                     // R11
                default: ;
            endcase
        end
        if (alloc) begin
            // R8 / R9
            s_d.valid[slot] = 1'b1;
            s_d.rg[slot]    = req_reg;
            s_d.ad[slot]    = req_addr;
            s_d.sz[slot]    = req_size;
            if (use_rr) begin
                s_d.rr = (s_q.rr == LAST_IDX) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;  // R1
        end else begin
            s_q <= s_d;
        end
    end

    assign chk_done = s_q.done;  // R12
    assign chk_hit  = s_q.hit;
endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [2:0]                    req_op,
    input logic                          req_spec_page,
    input logic                          req_defer,
    input logic                          chk_done,
    input logic                          chk_hit,
    input logic [ENTRIES-1:0]            ent_valid,
    input logic [ENTRIES-1:0][REG_W-1:0] ent_reg
);
    logic is_chk;
    int   dup_cnt;
    int   live_cnt;

    assign is_chk   = req_valid && (req_op == 3'd3 || req_op == 3'd4);
    assign live_cnt = $countones(ent_valid);

    always_comb begin
        dup_cnt = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (ent_valid[i] && ent_valid[j] && ent_reg[i] == ent_reg[j]) begin
                    dup_cnt++;
                end
            end
        end
    end

    // R12
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_chk |=> chk_done);
    // R12
    done_only_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_chk |=> !chk_done);
    // R12
    hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> !chk_hit);
    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd6) |=> (ent_valid == '0));
    // R13
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(ent_valid));
    // R8
    unique_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_cnt == 0);
    // R3
    defer_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2 && req_defer) |=> live_cnt <= $past(live_cnt));
    // R7
    nonspec_chk_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_chk && !req_spec_page) |=> live_cnt <= $past(live_cnt));
    // R9
    single_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> live_cnt <= $past(live_cnt) + 1);
endmodule

bind spec_load_table slt_checker #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_spec_page (req_spec_page),
    .req_defer     (req_defer),
    .chk_done      (chk_done),
    .chk_hit       (chk_hit),
    .ent_valid     (ent_valid_q),
    .ent_reg       (ent_reg_q)
);

// File: tb/tb_spec_load_table.sv
module tb_spec_load_table;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 40;

    typedef struct packed {
        logic [2:0]  op;
        logic        sp;
        logic        df;
        logic [6:0]  rg;
        logic [15:0] ad;
        logic [1:0]  sz;
        logic        ed;
        logic        eh;
        logic [3:0]  rq;
    } vec_t;

    // op codes: 1 adv, 2 spec adv, 3 check-clear, 4 check-keep, 5 store, 6 flush
    // probe = op 4 on a non-speculative page (never modifies the table)
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd1, 1'b1, 1'b0, 7'd5,  16'h0100, 2'd2, 1'b0, 1'b0, 4'd2},  // R2
        '{3'd4, 1'b0, 1'b0, 7'd5,  16'h0100, 2'd2, 1'b1, 1'b1, 4'd2},
        '{3'd4, 1'b0, 1'b0, 7'd5,  16'h0104, 2'd2, 1'b1, 1'b0, 4'd6},  // R6 exactness
        '{3'd3, 1'b1, 1'b0, 7'd5,  16'h0100, 2'd2, 1'b1, 1'b1, 4'd5},  // R5 hit
        '{3'd4, 1'b0, 1'b0, 7'd5,  16'h0100, 2'd2, 1'b1, 1'b0, 4'd5},
        '{3'd3, 1'b1, 1'b0, 7'd5,  16'h0100, 2'd2, 1'b1, 1'b0, 4'd5},  // R5 miss
        '{3'd2, 1'b1, 1'b0, 7'd6,  16'h0200, 2'd3, 1'b0, 1'b0, 4'd2},
        '{3'd4, 1'b0, 1'b0, 7'd6,  16'h0200, 2'd3, 1'b1, 1'b1, 4'd2},
        '{3'd2, 1'b1, 1'b1, 7'd6,  16'h0200, 2'd3, 1'b0, 1'b0, 4'd3},  // R3
        '{3'd4, 1'b0, 1'b0, 7'd6,  16'h0200, 2'd3, 1'b1, 1'b0, 4'd3},
        '{3'd2, 1'b1, 1'b1, 7'd7,  16'h0300, 2'd2, 1'b0, 1'b0, 4'd3},
        '{3'd4, 1'b0, 1'b0, 7'd7,  16'h0300, 2'd2, 1'b1, 1'b0, 4'd3},
        '{3'd1, 1'b1, 1'b0, 7'd8,  16'h0400, 2'd2, 1'b0, 1'b0, 4'd4},  // R4
        '{3'd1, 1'b0, 1'b0, 7'd8,  16'h0500, 2'd1, 1'b0, 1'b0, 4'd4},
        '{3'd4, 1'b0, 1'b0, 7'd8,  16'h0400, 2'd2, 1'b1, 1'b0, 4'd4},
        '{3'd4, 1'b0, 1'b0, 7'd8,  16'h0500, 2'd1, 1'b1, 1'b0, 4'd4},
        '{3'd1, 1'b1, 1'b0, 7'd13, 16'h0a00, 2'd2, 1'b0, 1'b0, 4'd4},
        '{3'd2, 1'b0, 1'b0, 7'd13, 16'h0a00, 2'd2, 1'b0, 1'b0, 4'd4},
        '{3'd4, 1'b0, 1'b0, 7'd13, 16'h0a00, 2'd2, 1'b1, 1'b0, 4'd4},
        '{3'd4, 1'b1, 1'b0, 7'd9,  16'h0600, 2'd2, 1'b1, 1'b0, 4'd6},  // R6 miss alloc
        '{3'd4, 1'b0, 1'b0, 7'd9,  16'h0600, 2'd2, 1'b1, 1'b1, 4'd6},
        '{3'd4, 1'b1, 1'b0, 7'd9,  16'h0600, 2'd2, 1'b1, 1'b1, 4'd6},  // R6 exact
        '{3'd4, 1'b0, 1'b0, 7'd9,  16'h0600, 2'd2, 1'b1, 1'b1, 4'd6},
        '{3'd4, 1'b1, 1'b0, 7'd9,  16'h0608, 2'd1, 1'b1, 1'b0, 4'd6},  // R6 partial
        '{3'd4, 1'b0, 1'b0, 7'd9,  16'h0608, 2'd1, 1'b1, 1'b1, 4'd6},
        '{3'd4, 1'b0, 1'b0, 7'd9,  16'h0600, 2'd2, 1'b1, 1'b0, 4'd8},
        '{3'd4, 1'b0, 1'b0, 7'd10, 16'h0700, 2'd2, 1'b1, 1'b0, 4'd7},  // R7
        '{3'd3, 1'b0, 1'b0, 7'd10, 16'h0700, 2'd2, 1'b1, 1'b0, 4'd7},
        '{3'd4, 1'b0, 1'b0, 7'd10, 16'h0700, 2'd2, 1'b1, 1'b0, 4'd7},
        '{3'd1, 1'b1, 1'b0, 7'd11, 16'h0800, 2'd2, 1'b0, 1'b0, 4'd8},  // R8
        '{3'd1, 1'b1, 1'b0, 7'd11, 16'h0900, 2'd0, 1'b0, 1'b0, 4'd8},
        '{3'd4, 1'b0, 1'b0, 7'd11, 16'h0800, 2'd2, 1'b1, 1'b0, 4'd8},
        '{3'd4, 1'b0, 1'b0, 7'd11, 16'h0900, 2'd0, 1'b1, 1'b1, 4'd8},
        '{3'd5, 1'b1, 1'b0, 7'd0,  16'h08fe, 2'd1, 1'b0, 1'b0, 4'd10}, // R10 no overlap
        '{3'd4, 1'b0, 1'b0, 7'd11, 16'h0900, 2'd0, 1'b1, 1'b1, 4'd10},
        '{3'd5, 1'b1, 1'b0, 7'd0,  16'h08ff, 2'd1, 1'b0, 1'b0, 4'd10}, // R10 overlap
        '{3'd4, 1'b0, 1'b0, 7'd11, 16'h0900, 2'd0, 1'b1, 1'b0, 4'd10},
        '{3'd6, 1'b0, 1'b0, 7'd0,  16'h0000, 2'd0, 1'b0, 1'b0, 4'd11}, // R11
        '{3'd4, 1'b0, 1'b0, 7'd9,  16'h0608, 2'd1, 1'b1, 1'b0, 4'd11},
        '{3'd4, 1'b0, 1'b0, 7'd9,  16'h0600, 2'd2, 1'b1, 1'b0, 4'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_spec_page = 1'b0;
    logic        req_defer = 1'b0;
    logic [6:0]  req_reg = '0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        chk_done, chk_hit;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spec_load_table dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_spec_page (req_spec_page),
        .req_defer     (req_defer),
        .req_reg       (req_reg),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .chk_done      (chk_done),
        .chk_hit       (chk_hit)
    );

    task automatic check(input int rq, input logic exp_done, input logic exp_hit);
        total++;
        if (chk_done !== exp_done || chk_hit !== exp_hit) begin
            bad++;
            $display("FAIL R%0d: done/hit actual=%b/%b expected=%b/%b",
                     rq, chk_done, chk_hit, exp_done, exp_hit);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic sp, input logic df,
                        input logic [6:0] rg, input logic [15:0] ad, input logic [1:0] sz);
        @(negedge clk);
        req_valid     = 1'b1;
        req_op        = op;
        req_spec_page = sp;
        req_defer     = df;
        req_reg       = rg;
        req_addr      = ad;
        req_size      = sz;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic probe(input logic [6:0] rg, input logic [15:0] ad,
                         input logic [1:0] sz, input logic exp, input int rq);
        send(3'd4, 1'b0, 1'b0, rg, ad, sz);
        check(rq, 1'b1, exp);
    endtask

    task automatic adv(input logic [6:0] rg, input logic [15:0] ad);
        send(3'd1, 1'b1, 1'b0, rg, ad, 2'd0);
        check(9, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, 1'b0, 1'b0);  // R1 reset state of outputs
        @(negedge clk);
        rst_n = 1'b1;
        probe(7'd5, 16'h0100, 2'd2, 1'b0, 1);  // R1 empty table

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].op, VECS[i].sp, VECS[i].df, VECS[i].rg, VECS[i].ad, VECS[i].sz);
            check(int'(VECS[i].rq), VECS[i].ed, VECS[i].eh);
        end

        // R13: idle cycle carrying a flush code must do nothing
        adv(7'd1, 16'h0010);
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = 3'd6;
        @(posedge clk);
        #1;
        check(13, 1'b0, 1'b0);
        probe(7'd1, 16'h0010, 2'd0, 1'b1, 13);

        // R9: fill table, then round-robin replacement and lowest-free reuse
        send(3'd6, 1'b0, 1'b0, 7'd0, 16'h0, 2'd0);
        check(11, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) adv(7'(20 + k), 16'(k * 256));
        adv(7'd28, 16'h2000);                      // replaces slot 0 (reg 20)
        probe(7'd20, 16'h0000, 2'd0, 1'b0, 9);
        probe(7'd21, 16'h0100, 2'd0, 1'b1, 9);
        probe(7'd28, 16'h2000, 2'd0, 1'b1, 9);
        adv(7'd29, 16'h2100);                      // replaces slot 1 (reg 21)
        probe(7'd21, 16'h0100, 2'd0, 1'b0, 9);
        probe(7'd22, 16'h0200, 2'd0, 1'b1, 9);
        send(3'd3, 1'b1, 1'b0, 7'd24, 16'h0400, 2'd0);  // free slot 4
        check(5, 1'b1, 1'b1);
        adv(7'd30, 16'h2200);                      // takes free slot 4, pointer kept
        probe(7'd30, 16'h2200, 2'd0, 1'b1, 9);
        probe(7'd22, 16'h0200, 2'd0, 1'b1, 9);
        adv(7'd31, 16'h2300);                      // replaces slot 2 (reg 22)
        probe(7'd22, 16'h0200, 2'd0, 1'b0, 9);
        probe(7'd23, 16'h0300, 2'd0, 1'b1, 9);
        probe(7'd31, 16'h2300, 2'd0, 1'b1, 9);

        // R12: back-to-back check-clear then probe sees removal immediately
        send(3'd3, 1'b1, 1'b0, 7'd23, 16'h0300, 2'd0);
        check(12, 1'b1, 1'b1);
        probe(7'd23, 16'h0300, 2'd0, 1'b0, 12);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule